// File: doc/BRIEF.md
# Fan-in-Parameterized Tree Carry Adder

This block is a purely combinational unsigned adder. It adds two `WIDTH`-bit operands and returns a `WIDTH+1`-bit sum. The carry into the least significant bit is fixed at zero.

Each bit first produces a generate term and a propagate term. A parallel-prefix carry network then folds these terms together with the associative generate/propagate merge. Every node of that network merges `FANIN/2` neighbouring pairs in a single level, where the usual textbook tree merges only two. The network therefore needs only ceil(lg WIDTH / (lg FANIN − 1)) levels. Nodes are shared between the overlapping trees that deliver the individual prefix carries.

A final layer forms each sum bit from the operand bits and the carry arriving from below. `WIDTH` need not be a power of `FANIN/2`: a merge input that would reach below bit 0 is padded with the identity pair.

Top module: `tree_carry_adder`

## Requirements
- R1: For every pair of operands, `sum_o` equals the unsigned sum `x_i + y_i`, extended to `WIDTH+1` bits.
- R2: `sum_o[0]` equals `x_i[0] XOR y_i[0]`, because the carry into bit 0 is zero.
- R3: `sum_o[WIDTH]` is the carry out of bit `WIDTH-1`, so an all-ones operand plus 1 gives exactly 2^WIDTH.
- R4: The parameter `PROP_OR` selects the propagate term. With 0 it is the XOR of the operand bits; with 1 it is their OR. The sum is identical in both modes, because sum bits always use the XOR of the operands.
- R5: The carry out of bit i obeys the ripple recurrence: the carry out of bit i is the generate of bit i, OR the propagate of bit i AND the carry out of bit i−1. This holds even for carry chains that run across the full width.
- R6: The prefix propagate that the network delivers at bit i is the AND of the per-bit propagates over bits i down to 0. As a result, x + ~x gives all ones with no carry out.
- R7: The sum is correct when `WIDTH` is not a power of `FANIN/2`, for example `WIDTH=13` with `FANIN=6`.
- R8: All ones plus all ones gives 2^(WIDTH+1) − 2.
- R9: Zero plus zero gives a sum of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First unsigned operand |
| y_i | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH+1 | Unsigned sum; the top bit is the carry out |

## Verification
The adder holds no state, so a fault in any merge node or padding tap shows at `sum_o` in the same evaluation that the operands change. A faulty node at level l only distorts carries whose chain is longer than (FANIN/2)^l bits. For that reason the stimulus includes carry chains of every length from 1 to the full width, along with full-propagate and full-generate operands. Several width and fan-in pairings, including a partially filled top group and the OR propagate mode, all run the same stimulus. This exposes errors in tap offsets and padding that a single configuration could hide.

// File: rtl/tca_pkg.sv
package tca_pkg;
    // Number of merge levels needed so that a span of grp**levels covers width bits.
    function automatic int tca_levels(input int width, input int grp);
        int lv;
        int reach;
        lv = 0;
        reach = 1;
        while (reach < width) begin
            reach = reach * grp;
            lv++;
        end
        return lv;
    endfunction
endpackage

// File: rtl/tca_gp_layer.sv
module tca_gp_layer #(
    parameter int WIDTH   = 32,
    parameter bit PROP_OR = 1'b0
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);
    assign g_o = x_i & y_i;
    if (PROP_OR) begin : g_prop_or
        assign p_o = x_i | y_i;
    end else begin : g_prop_xor
        assign p_o = x_i ^ y_i;
    end
endmodule

// File: rtl/tca_merge_node.sv
// Merges GRP adjacent (g,p) pairs; index 0 is the least significant pair.
module tca_merge_node #(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] g_i,
    input  logic [GRP-1:0] p_i,
    output logic           g_o,
    output logic           p_o
);
    always_comb begin
        logic term;
        g_o = 1'b0;
        p_o = &p_i;
        // Triangle: some pair generates and every more significant pair propagates.
        for (int j = 0; j < GRP; j++) begin
            term = g_i[j];
            for (int k = j + 1; k < GRP; k++) begin
                term = term & p_i[k];
            end
            g_o = g_o | term;
        end
    end
endmodule

// File: rtl/tca_prefix_net.sv
module tca_prefix_net #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    output logic [WIDTH-1:0] carry_o,
    output logic [WIDTH-1:0] blk_p_o
);
    localparam int LVLS = tca_pkg::tca_levels(WIDTH, GRP);

    logic [LVLS:0][WIDTH-1:0] stg_g;
    logic [LVLS:0][WIDTH-1:0] stg_p;

    assign stg_g[0] = g_i;
    assign stg_p[0] = p_i;

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int SPAN = GRP ** l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [GRP-1:0] in_g;
            logic [GRP-1:0] in_p;
            for (genvar j = 0; j < GRP; j++) begin : g_tap
                localparam int SRC = i - j * SPAN;
                if (SRC >= 0) begin : g_live
                    assign in_g[GRP-1-j] = stg_g[l][SRC];
                    assign in_p[GRP-1-j] = stg_p[l][SRC];
                end else begin : g_pad
                    assign in_g[GRP-1-j] = 1'b0;
                    assign in_p[GRP-1-j] = 1'b1;
                end
            end
            tca_merge_node #(.GRP(GRP)) node_i (
                .g_i (in_g),
                .p_i (in_p),
                .g_o (stg_g[l+1][i]),
                .p_o (stg_p[l+1][i])
            );
        end
    end

    assign carry_o = stg_g[LVLS];
    assign blk_p_o = stg_p[LVLS];
endmodule

// File: rtl/tca_sum_layer.sv
module tca_sum_layer #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH:0]   sum_o
);
    logic [WIDTH-1:0] cin;
    if (WIDTH > 1) begin : g_shift
        assign cin = {carry_i[WIDTH-2:0], 1'b0};
    end else begin : g_single
        assign cin = 1'b0;
    end
    assign sum_o = {carry_i[WIDTH-1], x_i ^ y_i ^ cin};
endmodule

// File: rtl/tree_carry_adder.sv
module tree_carry_adder #(
    parameter int WIDTH   = 32,
    parameter int FANIN   = 8,
    parameter bit PROP_OR = 1'b0
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH:0]   sum_o
);
    localparam int GRP = FANIN / 2;

    if (FANIN < 4 || (FANIN % 2) != 0) begin : g_bad_fanin
        $error("FANIN must be even and at least 4");
    end

    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH-1:0] carry_w;
    logic [WIDTH-1:0] blk_p_w;

    tca_gp_layer #(.WIDTH(WIDTH), .PROP_OR(PROP_OR)) gp_i (
        .x_i (x_i),
        .y_i (y_i),
        .g_o (gen_w),
        .p_o (prop_w)
    );

    tca_prefix_net #(.WIDTH(WIDTH), .GRP(GRP)) net_i (
        .g_i     (gen_w),
        .p_i     (prop_w),
        .carry_o (carry_w),
        .blk_p_o (blk_p_w)
    );

    tca_sum_layer #(.WIDTH(WIDTH)) sum_i (
        .x_i     (x_i),
        .y_i     (y_i),
        .carry_i (carry_w),
        .sum_o   (sum_o)
    );
endmodule

// File: rtl/tca_checker.sv
module tca_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] x_i,
    input logic [WIDTH-1:0] y_i,
    input logic [WIDTH:0]   sum_o,
    input logic [WIDTH-1:0] prop_w,
    input logic [WIDTH-1:0] carry_w,
    input logic [WIDTH-1:0] blk_p_w
);
    always_comb begin
        logic run_p;
        if (!$isunknown({x_i, y_i})) begin
            assert_sum_exact_R1: assert (sum_o == ({1'b0, x_i} + {1'b0, y_i}))
                else $error("sum mismatch");
            assert_lsb_no_cin_R2: assert (sum_o[0] == (x_i[0] ^ y_i[0]))
                else $error("lsb wrong");
            assert_top_is_cout_R3: assert (sum_o[WIDTH] == carry_w[WIDTH-1])
                else $error("top bit not carry out");
            run_p = prop_w[0];
            assert_ripple_base_R5: assert (carry_w[0] == (x_i[0] & y_i[0]))
                else $error("carry 0 wrong");
            assert_blkp_base_R6: assert (blk_p_w[0] == run_p)
                else $error("prefix propagate 0 wrong");
            for (int i = 1; i < WIDTH; i++) begin
                run_p = run_p & prop_w[i];
                assert_ripple_R5: assert (carry_w[i] ==
                        ((x_i[i] & y_i[i]) | (prop_w[i] & carry_w[i-1])))
                    else $error("carry %0d breaks recurrence", i);
                assert_blk_prop_R6: assert (blk_p_w[i] == run_p)
                    else $error("prefix propagate %0d wrong", i);
            end
        end
    end
endmodule

bind tree_carry_adder tca_checker #(.WIDTH(WIDTH)) chk_i (
    .x_i     (x_i),
    .y_i     (y_i),
    .sum_o   (sum_o),
    .prop_w  (prop_w),
    .carry_w (carry_w),
    .blk_p_w (blk_p_w)
);

// File: tb/tree_carry_adder_tb_top.sv
`timescale 1ns/1ps
module tree_carry_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] xv = '0;
    logic [31:0] yv = '0;

    logic [32:0] sum_a;
    logic [13:0] sum_b;
    logic [8:0]  sum_c;
    logic [32:0] sum_d;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [32:0] e_a;
        logic [13:0] e_b;
        logic [8:0]  e_c;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    tree_carry_adder #(.WIDTH(32), .FANIN(8), .PROP_OR(1'b0)) dut_i (
        .x_i(xv), .y_i(yv), .sum_o(sum_a));
    tree_carry_adder #(.WIDTH(13), .FANIN(6), .PROP_OR(1'b1)) dut_b (
        .x_i(xv[12:0]), .y_i(yv[12:0]), .sum_o(sum_b));
    tree_carry_adder #(.WIDTH(8), .FANIN(4), .PROP_OR(1'b0)) dut_c (
        .x_i(xv[7:0]), .y_i(yv[7:0]), .sum_o(sum_c));
    tree_carry_adder #(.WIDTH(32), .FANIN(8), .PROP_OR(1'b1)) dut_d (
        .x_i(xv), .y_i(yv), .sum_o(sum_d));

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t it;
        @(negedge clk);
        xv = a;
        yv = b;
        it.e_a = {1'b0, a} + {1'b0, b};
        it.e_b = {1'b0, a[12:0]} + {1'b0, b[12:0]};
        it.e_c = {1'b0, a[7:0]} + {1'b0, b[7:0]};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic cmp(input string tag, input string who, input logic [32:0] got,
                       input logic [32:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, who, got, exp);
        end
    endtask

    // Monitor: compare at posedge, half a cycle after the negedge drive.
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                cmp(it.tag, "dut_i(32,8)", sum_a, it.e_a);
                cmp(it.tag, "dut_b(13,6,or) R7", {19'd0, sum_b}, {19'd0, it.e_b});
                cmp(it.tag, "dut_c(8,4)", {24'd0, sum_c}, {24'd0, it.e_c});
                cmp(it.tag, "dut_d(32,8,or) R4", sum_d, it.e_a);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: zero operands while in reset
        drive(32'd0, 32'd0, "R9 reset zero");
        drive(32'd0, 32'd0, "R9 zero");
        @(negedge clk);
        rst = 1'b0;
        // R2: least significant bit without carry in
        drive(32'd1, 32'd0, "R2 lsb 1+0");
        drive(32'd1, 32'd1, "R2 lsb 1+1");
        drive(32'd0, 32'd1, "R2 lsb 0+1");
        // R3: all ones plus one
        drive(32'hFFFF_FFFF, 32'd1, "R3 ones+1");
        drive(32'd1, 32'hFFFF_FFFF, "R3 1+ones");
        // R8: all ones plus all ones
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 ones+ones");
        // R5: carry chains of every length
        for (int k = 1; k <= 32; k++) begin
            drive(32'hFFFF_FFFF >> (32 - k), 32'd1, "R5 chain");
            drive(32'd1 << (k - 1), 32'd1 << (k - 1), "R5 single gen");
        end
        // R6: full propagate, no generate
        drive(32'hA5A5_0F0F, ~32'hA5A5_0F0F, "R6 x+~x");
        drive(32'd0, 32'hFFFF_FFFF, "R6 0+ones");
        drive(32'h1234_5678, ~32'h1234_5678, "R6 x+~x b");
        // R1 / R4 / R7: random operands on all configurations
        for (int r = 0; r < 300; r++) begin
            drive($urandom, $urandom, "R1 random");
        end
        drive(32'd0, 32'd0, "R9 zero final");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule